// File: doc/BRIEF.md
# SPI Follower Front End with Frame-Length Checking

This block is the serial front end of a register-based peripheral. It exchanges data with an SPI controller over four wires: an active-low chip select, a serial clock, data in and data out. Every access opens with chip select falling and closes with chip select rising. Input bits are captured on the falling edge of the serial clock. Output bits change on the rising edge. All three input lines are brought into the system clock domain and edge-detected there.

A single 16-bit shift register does both directions. When chip select falls, it is loaded with the response word. That word is the transmission-error flag, followed by 15 bits of reply data from the register logic. Each received bit enters at the low end. The top bit goes out on the data-out line, so any bits after the first 16 pass straight through. This lets the block sit in a daisy chain.

A bit counter wraps at 16 for the first word and at 8 after that. When the access ends, the frame is accepted only if the count stopped exactly on one of those boundaries. This allows the block to share a chain with both 8-bit and 16-bit devices. An accepted frame is handed to the register logic as a parallel word with a one-cycle strobe. A rejected frame is dropped and raises the error flag.

Top module: `spi_frame_follower`

## Requirements
- R1: After reset, `sdo_en` and `rx_valid` are 0 and the error flag is clear, so the first access returns 0 as the first bit on `sdo`.
- R2: `sdi` is captured on each falling edge of `sck` while chip select is low. On an accepted frame, `rx_word` holds the last 16 bits received. The earliest of those bits is at bit 15 and the latest at bit 0.
- R3: `sdo` changes only on a rising edge of `sck`. The first 16 bits sent are the response word, MSB first. Bit 15 of the response word is the error flag and bits 14..0 are `tx_data`.
- R4: From bit 17 of an access onward, `sdo` repeats the bits received on `sdi`, delayed by 16 bit periods.
- R5: A frame of 16 + 8k bits (k >= 0) is accepted. `rx_valid` is high for exactly one system clock, 3 clocks after chip select rises at the pin.
- R6: A frame of any other length, including one shorter than 16 bits, gives no `rx_valid` pulse and sets the error flag. The next access then sends 1 as its first `sdo` bit.
- R7: An accepted frame clears the error flag. The next access then sends 0 as its first `sdo` bit.
- R8: `sdo_en` is 1 while the synchronized chip select is low and 0 while it is high, within 2 system clocks of a change at the pin.
- R9: `sck` edges while chip select is high neither count nor shift.
- R10: `tx_data` is captured at the falling edge of chip select. Changes to it during the access do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select from the controller |
| sck | input | 1 | Serial clock from the controller |
| sdi | input | 1 | Serial data in |
| tx_data | input | 15 | Reply data placed below the error flag in the response word |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for the data-out pad driver; the pad is high-impedance when 0 |
| rx_word | output | 16 | Last 16 bits of an accepted frame |
| rx_valid | output | 1 | One-clock strobe marking `rx_word` as new |

## Verification
Each pin change passes through two synchronizer flops and one edge-detect register before it takes effect. The bench drives every input one time unit after a falling system clock edge. It then expects `rx_valid` and `rx_word` exactly 3 clocks after the chip select rise, and `sdo_en` 2 clocks after a chip select change. A reference model in the bench records when each strobe is due and compares `rx_valid` against that schedule on every clock. Any strobe that comes early, late or for a rejected frame is therefore caught. Each serial half period lasts 6 system clocks. `sdo` is compared against the expected response or pass-through bit at the end of each high phase, well after its 3-clock update delay.

// File: rtl/spi_ff_pkg.sv
`timescale 1ns/1ps
package spi_ff_pkg;

    localparam int WORD_W  = 16;
    localparam int GROUP_W = 8;
    localparam int CNT_W   = $clog2(WORD_W);

    // Bit counter: first word phase, then repeating groups
    typedef struct packed {
        logic             past_first;
        logic [CNT_W-1:0] cnt;
    } bitcnt_t;

    // Synchronized pin events in the system clock domain
    typedef struct packed {
        logic cs_low;
        logic cs_fall;
        logic cs_rise;
        logic sck_rise;
        logic sck_fall;
        logic sdi;
    } pin_ev_t;

    function automatic bitcnt_t count_step(bitcnt_t c);
        bitcnt_t n;
        n = c;
        if (!c.past_first) begin
            if (c.cnt == CNT_W'(WORD_W - 1)) begin
                n.past_first = 1'b1;
                n.cnt        = '0;
            end else begin
                n.cnt = c.cnt + 1'b1;
            end
        end else if (c.cnt == CNT_W'(GROUP_W - 1)) begin
            n.cnt = '0;
        end else begin
            n.cnt = c.cnt + 1'b1;
        end
        return n;
    endfunction

    function automatic logic length_ok(bitcnt_t c);
        return c.past_first && (c.cnt == '0);
    endfunction

endpackage

// File: rtl/spi_ff_sync.sv
`timescale 1ns/1ps
module spi_ff_sync
    import spi_ff_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    sck,
    input  logic    sdi,
    output pin_ev_t ev
);
    localparam int   LINES   = 3;
    localparam logic [LINES-1:0] RST_VAL = 3'b001;  // cs_n idles high

    logic [LINES-1:0] raw;
    logic [LINES-1:0] line_s;
    logic [LINES-1:0] line_p;

    assign raw = {sdi, sck, cs_n};

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [SYNC_STAGES:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= {(SYNC_STAGES + 1){RST_VAL[i]}};
            else     pipe <= {pipe[SYNC_STAGES-1:0], raw[i]};
        end
        assign line_s[i] = pipe[SYNC_STAGES-1];
        assign line_p[i] = pipe[SYNC_STAGES];
    end

    always_comb begin
        ev.cs_low   = ~line_s[0];
        ev.cs_fall  =  line_p[0] & ~line_s[0];
        ev.cs_rise  = ~line_p[0] &  line_s[0];
        ev.sck_rise = ~line_p[1] &  line_s[1] & ~line_s[0];
        ev.sck_fall =  line_p[1] & ~line_s[1] & ~line_s[0];
        ev.sdi      =  line_s[2];
    end

endmodule

// File: rtl/spi_ff_shift.sv
`timescale 1ns/1ps
module spi_ff_shift
    import spi_ff_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pin_ev_t           ev,
    input  logic [WORD_W-1:0] load_word,
    output logic [WORD_W-1:0] sr_q,
    output logic              sdo_q,
    output logic              len_ok
);
    bitcnt_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            sdo_q <= 1'b0;
            cnt_q <= '0;
        end else if (ev.cs_fall) begin
            sr_q  <= load_word;
            cnt_q <= '0;
        end else begin
            if (ev.sck_fall) begin
                sr_q  <= {sr_q[WORD_W-2:0], ev.sdi};
                cnt_q <= count_step(cnt_q);
            end
            if (ev.sck_rise) begin
                sdo_q <= sr_q[WORD_W-1];
            end
        end
    end

    assign len_ok = length_ok(cnt_q);

    // R9: with chip select idle, neither count nor data moves
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !ev.cs_low |=> ($stable(cnt_q) && $stable(sr_q)));

    // R5: after the first word the counter stays inside one group
    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q.past_first |-> (cnt_q.cnt < CNT_W'(GROUP_W)));

endmodule

// File: rtl/spi_ff_frame.sv
`timescale 1ns/1ps
module spi_ff_frame
    import spi_ff_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_rise,
    input  logic              len_ok,
    input  logic [WORD_W-1:0] sr_q,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              ter_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_word  <= '0;
            rx_valid <= 1'b0;
            ter_q    <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (cs_rise) begin
                if (len_ok) begin
                    rx_word  <= sr_q;
                    rx_valid <= 1'b1;
                    ter_q    <= 1'b0;
                end else begin
                    ter_q    <= 1'b1;
                end
            end
        end
    end

    // R5: strobe lasts one clock
    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R7: an accepted frame leaves the error flag clear
    assert_valid_clears_R7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !ter_q);

endmodule

// File: rtl/spi_frame_follower.sv
`timescale 1ns/1ps
module spi_frame_follower
    import spi_ff_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic [WORD_W-2:0] tx_data,
    output logic              sdo,
    output logic              sdo_en,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);
    pin_ev_t           ev;
    logic [WORD_W-1:0] sr_q;
    logic              len_ok;
    logic              ter_q;

    spi_ff_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .cs_n(cs_n),
        .sck (sck),
        .sdi (sdi),
        .ev  (ev)
    );

    spi_ff_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .load_word({ter_q, tx_data}),
        .sr_q     (sr_q),
        .sdo_q    (sdo),
        .len_ok   (len_ok)
    );

    spi_ff_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .cs_rise (ev.cs_rise),
        .len_ok  (len_ok),
        .sr_q    (sr_q),
        .rx_word (rx_word),
        .rx_valid(rx_valid),
        .ter_q   (ter_q)
    );

    assign sdo_en = ev.cs_low;

    // R6: a frame ending off a boundary raises the error flag
    assert_bad_len_sets_ter_R6: assert property (@(posedge clk) disable iff (rst)
        (ev.cs_rise && !len_ok) |=> (ter_q && !rx_valid));

    // R8 / R3: data out cannot move while the output is disabled
    assert_sdo_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !sdo_en |=> $stable(sdo));

endmodule

// File: tb/spi_frame_follower_bench.sv
`timescale 1ns/1ps
module spi_frame_follower_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic [14:0] tx_data = '0;
    logic        sdo;
    logic        sdo_en;
    logic [15:0] rx_word;
    logic        rx_valid;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int due_valid = -100;
    logic [15:0] exp_word = '0;
    logic        m_ter = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    spi_frame_follower u_spi_frame_follower (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .tx_data(tx_data), .sdo(sdo), .sdo_en(sdo_en),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h cycle=%0d", req, act, exp, cyc);
        end
    endtask

    // Reference schedule: strobe due exactly on cycle due_valid (R5, R6)
    always @(negedge clk) begin
        if (!rst) begin
            chk("R5 strobe timing", {15'd0, rx_valid}, {15'd0, (cyc == due_valid)});
            if (cyc == due_valid) chk("R2 received word", rx_word, exp_word);
        end
    end

    task automatic wd(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic access(input int nbits, input logic [63:0] pat, input bit change_tx);
        logic [15:0] resp;
        logic        expb;
        bit          ok;
        resp = {m_ter, tx_data};
        wd(1);
        cs_n = 1'b0;
        wd(6);
        chk("R8 enable while selected", {15'd0, sdo_en}, 16'd1);
        for (int i = 0; i < nbits; i++) begin
            sck = 1'b1;
            sdi = pat[nbits-1-i];
            wd(6);
            if (i < 16) begin
                expb = resp[15-i];
                chk((i == 0) ? "R1/R6/R7 error flag bit" : "R3 response bit", {15'd0, sdo}, {15'd0, expb});
            end else begin
                expb = pat[nbits-1-(i-16)];
                chk("R4 pass-through bit", {15'd0, sdo}, {15'd0, expb});
            end
            if (change_tx && i == 2) tx_data = ~tx_data;  // R10
            sck = 1'b0;
            wd(6);
        end
        cs_n = 1'b1;
        ok = (nbits >= 16) && (((nbits - 16) % 8) == 0);
        if (ok) begin
            due_valid = cyc + 3;
            exp_word  = pat[15:0];
        end
        m_ter = !ok;
        wd(8);
        chk("R8 disable while idle", {15'd0, sdo_en}, 16'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wd(4);
        chk("R1 reset enable", {15'd0, sdo_en}, 16'd0);
        chk("R1 reset strobe", {15'd0, rx_valid}, 16'd0);
        rst = 1'b0;
        wd(4);
        chk("R1 idle enable", {15'd0, sdo_en}, 16'd0);

        tx_data = 15'h1234;
        access(16, 64'hA5C3, 0);                 // R1 R2 R3 R5
        tx_data = 15'h0F0F;
        access(24, 64'h3C_96E1, 0);              // R4 R5
        access(12, 64'hABC, 0);                  // R6 short
        tx_data = 15'h7001;
        access(16, 64'h1357, 0);                 // R6 flag sent, then R7
        access(20, 64'hF_0F0F, 0);               // R6 not on boundary
        tx_data = 15'h2AAA;
        access(32, 64'hDEAD_BEEF, 1);            // R10 change mid access
        access(16, 64'h8001, 0);                 // R7 flag cleared
        for (int k = 0; k < 5; k++) begin         // R9 edges while idle
            sck = 1'b1; wd(6);
            sck = 1'b0; wd(6);
        end
        access(16, 64'h55AA, 0);                 // R9 count unaffected
        access(40, 64'h12_3456_789A, 0);         // R5 16+3*8
        wd(10);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule